// File: doc/BRIEF.md
# Control Endpoint Status Interlock

This block holds the control and status byte of a USB control endpoint, together with its companion byte-count register. Two masters can write this state: the serial interface engine (SIE), which reports packet events as single-cycle strobes, and the CPU, which reads and writes over a simple register port. The byte carries four event flags in its upper nibble and the endpoint mode in its lower nibble. The SIE drives the flags and may also load the mode and the count.

Whenever the SIE updates either register, a lock is set. While the lock is set, CPU writes to the control byte and the count are dropped, so software cannot overwrite an update it has not yet seen. Any cycle that raises the CPU read strobe for the control byte opens the lock again. This includes a write cycle that also raises the read strobe, and such a write is then accepted. An accepted CPU write to the control byte always clears the four flags, whatever data it carries, and loads only the mode field.

From the first data packet of a SETUP transaction until the ACK goes out, the setup flag is held at 1. While that flag is 1, CPU writes to the endpoint data buffer are masked, so pending setup bytes are kept until software has read them.

Top module: `ep_ctl_interlock`

## Requirements
- R1: The control byte reads as {setup, in, out, acked, mode[3:0]}, with setup in bit 7, IN in bit 6, OUT in bit 5, acked in bit 4 and the mode in bits 3:0. Reset clears the byte, the count and the lock to 0.
- R2: Each of these sets the lock at the end of its cycle: a setup-start, IN-acked, OUT-done or transaction-acked strobe, an SIE mode write, or an SIE count write.
- R3: A cycle with the CPU read strobe and no SIE update clears the lock. When both fall in the same cycle, the lock ends up set.
- R4: While the lock is set and the read strobe is low, CPU writes to the control byte and to the count change nothing.
- R5: A CPU write in a cycle that also raises the read strobe is accepted, even if the lock was set.
- R6: An accepted CPU control write clears bits 7:4 and loads bits 3:0 from write data bits 3:0. An accepted CPU count write loads the count from the write data.
- R7: A setup-start strobe sets the setup flag on the next cycle. The flag stays 1 up to and including the cycle of the ACK-sent strobe, and CPU writes in that window do not clear it.
- R8: While the setup flag is 1, buffer write enable stays 0 and buffer-blocked is 1. Otherwise buffer write enable follows the CPU buffer write request.
- R9: The IN-acked, OUT-done and transaction-acked strobes each set their own flag (bit 6, bit 5, bit 4) on the next cycle. A cycle without the strobe leaves the flag unset.
- R10: A flag-setting strobe in the same cycle as an accepted CPU control write leaves that flag at 1.
- R11: An SIE mode write loads the mode field and takes priority over a CPU mode write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU read strobe of the control byte |
| cpu_wr_ctl | input | 1 | CPU write of the control byte |
| cpu_wr_cnt | input | 1 | CPU write of the count register |
| cpu_wr_buf | input | 1 | CPU write request to the endpoint data buffer |
| cpu_wdata | input | 8 | CPU write data |
| sie_setup_start | input | 1 | Start of the SETUP data packet |
| sie_ack_sent | input | 1 | Start of the ACK closing the SETUP transaction |
| sie_in_acked | input | 1 | Host ACKed an IN data packet |
| sie_out_done | input | 1 | Last packet of an ACKed OUT transaction done |
| sie_txn_acked | input | 1 | Any transaction ended with ACK |
| sie_mode_wr | input | 1 | SIE mode field write |
| sie_mode | input | 4 | SIE mode value |
| sie_cnt_wr | input | 1 | SIE count register write |
| sie_cnt | input | CNT_W | SIE count value |
| ctl_rdata | output | 8 | Control byte |
| cnt_rdata | output | CNT_W | Count register |
| lock_o | output | 1 | Current lock state |
| buf_wr_en | output | 1 | Gated buffer write enable |
| buf_wr_blocked | output | 1 | Buffer writes masked by pending setup |

## Verification
Three collisions can happen within one cycle. An SIE update can land in the same cycle as the CPU read that should release the lock. An SIE flag or mode set can land in the same cycle as an accepted CPU write that clears or loads the same field. A CPU clear can be attempted while the setup window is open. Directed sequences line up each collision on a single edge. A long random stream with dense strobes then produces them again and again. Every cycle is judged against a behavioural model in which the SIE set always wins and the lock ends up set.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;

  localparam int FLAG_N = 4;
  localparam int MODE_W = 4;
  localparam int BYTE_W = FLAG_N + MODE_W;

  // positions of the flags inside the upper nibble (offset from MODE_W)
  localparam int POS_ACKD  = 0;
  localparam int POS_OUT   = 1;
  localparam int POS_IN    = 2;
  localparam int POS_SETUP = 3;

  // set dominates clear, clear dominates hold
  function automatic logic set_clr_next(input logic set, input logic clr,
                                        input logic q);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return q;
  endfunction

  // SIE update locks, CPU read unlocks, SIE wins a tie
  function automatic logic lock_next(input logic sie_upd, input logic rd,
                                     input logic q);
    return set_clr_next(sie_upd, rd, q);
  endfunction

  // a CPU write gets through when unlocked or when the cycle carries a read
  function automatic logic write_open(input logic lock_q, input logic rd);
    return !lock_q || rd;
  endfunction

endpackage

// File: rtl/ep_lock_ctl.sv
module ep_lock_ctl
  import ep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sie_upd,
  input  logic cpu_rd,
  output logic lock_q,
  output logic wr_open
);

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_next(sie_upd, cpu_rd, lock_q);
  end

  assign wr_open = write_open(lock_q, cpu_rd);

endmodule

// File: rtl/ep_setup_track.sv
module ep_setup_track
  import ep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_sent,
  input  logic cpu_clr,
  output logic setup_q,
  output logic win_q
);

  logic pin_hi;

  // flag is pinned while the window is open and on the opening strobe
  assign pin_hi = start || win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      setup_q <= 1'b0;
    end else begin
      win_q   <= set_clr_next(start, ack_sent, win_q);
      setup_q <= set_clr_next(pin_hi, cpu_clr, setup_q);
    end
  end

endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank
  import ep_ctl_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set_clr_next(set[i], clr, q[i]);
    end
  end

endmodule

// File: rtl/ep_field_reg.sv
module ep_field_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sie_we,
  input  logic [W-1:0] sie_d,
  input  logic         cpu_we,
  input  logic [W-1:0] cpu_d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (sie_we) q <= sie_d;
    else if (cpu_we) q <= cpu_d;
  end

endmodule

// File: rtl/ep_ctl_interlock.sv
module ep_ctl_interlock
  import ep_ctl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_rd,
  input  logic                cpu_wr_ctl,
  input  logic                cpu_wr_cnt,
  input  logic                cpu_wr_buf,
  input  logic [BYTE_W-1:0]   cpu_wdata,
  input  logic                sie_setup_start,
  input  logic                sie_ack_sent,
  input  logic                sie_in_acked,
  input  logic                sie_out_done,
  input  logic                sie_txn_acked,
  input  logic                sie_mode_wr,
  input  logic [MODE_W-1:0]   sie_mode,
  input  logic                sie_cnt_wr,
  input  logic [CNT_W-1:0]    sie_cnt,
  output logic [BYTE_W-1:0]   ctl_rdata,
  output logic [CNT_W-1:0]    cnt_rdata,
  output logic                lock_o,
  output logic                buf_wr_en,
  output logic                buf_wr_blocked
);

  localparam int EV_N = FLAG_N - 1;

  // named internal events
  logic              sie_upd;
  logic              wr_open;
  logic              ctl_wr_ok;
  logic              cnt_wr_ok;
  logic              setup_q;
  logic              setup_win;
  logic [EV_N-1:0]   ev_set;
  logic [EV_N-1:0]   ev_q;
  logic [MODE_W-1:0] mode_q;

  assign sie_upd = sie_setup_start | sie_in_acked | sie_out_done |
                   sie_txn_acked | sie_mode_wr | sie_cnt_wr;

  ep_lock_ctl u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .sie_upd (sie_upd),
    .cpu_rd  (cpu_rd),
    .lock_q  (lock_o),
    .wr_open (wr_open)
  );

  assign ctl_wr_ok = cpu_wr_ctl && wr_open;
  assign cnt_wr_ok = cpu_wr_cnt && wr_open;

  ep_setup_track u_setup (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sie_setup_start),
    .ack_sent (sie_ack_sent),
    .cpu_clr  (ctl_wr_ok),
    .setup_q  (setup_q),
    .win_q    (setup_win)
  );

  assign ev_set[POS_ACKD] = sie_txn_acked;
  assign ev_set[POS_OUT]  = sie_out_done;
  assign ev_set[POS_IN]   = sie_in_acked;

  ep_flag_bank #(.N(EV_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr   (ctl_wr_ok),
    .q     (ev_q)
  );

  ep_field_reg #(.W(MODE_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .sie_we (sie_mode_wr),
    .sie_d  (sie_mode),
    .cpu_we (ctl_wr_ok),
    .cpu_d  (cpu_wdata[MODE_W-1:0]),
    .q      (mode_q)
  );

  ep_field_reg #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .sie_we (sie_cnt_wr),
    .sie_d  (sie_cnt),
    .cpu_we (cnt_wr_ok),
    .cpu_d  (cpu_wdata[CNT_W-1:0]),
    .q      (cnt_rdata)
  );

  assign ctl_rdata      = {setup_q, ev_q, mode_q};
  assign buf_wr_blocked = setup_q | setup_win;
  assign buf_wr_en      = cpu_wr_buf & ~buf_wr_blocked;

endmodule

// File: rtl/ep_ctl_interlock_chk.sv
module ep_ctl_interlock_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_rd,
  input logic             cpu_wr_ctl,
  input logic             cpu_wr_cnt,
  input logic [7:0]       cpu_wdata,
  input logic             sie_in_acked,
  input logic             sie_out_done,
  input logic             sie_mode_wr,
  input logic [3:0]       sie_mode,
  input logic             sie_upd,
  input logic             setup_win,
  input logic [7:0]       ctl_rdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             lock_o,
  input logic             buf_wr_en,
  input logic             buf_wr_blocked
);

  a_r2_sie_locks: assert property (@(posedge clk) disable iff (!rst_n)
    sie_upd |=> lock_o);

  a_r3_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !sie_upd) |=> !lock_o);

  a_r4_locked_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !cpu_rd && !sie_upd && cpu_wr_cnt) |=> $stable(cnt_rdata));

  a_r4_locked_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !cpu_rd && !sie_upd && cpu_wr_ctl) |=> $stable(ctl_rdata));

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_ctl && (!lock_o || cpu_rd) && !sie_upd && !setup_win)
      |=> (ctl_rdata == {4'h0, $past(cpu_wdata[3:0])}));

  a_r7_window_pins: assert property (@(posedge clk) disable iff (!rst_n)
    setup_win |-> ctl_rdata[7]);

  a_r8_buf_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7] |-> (buf_wr_blocked && !buf_wr_en));

  a_r9_in_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[6]) |-> $past(sie_in_acked));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sie_out_done |=> ctl_rdata[5]);

  a_r11_sie_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sie_mode_wr |=> (ctl_rdata[3:0] == $past(sie_mode)));

endmodule

bind ep_ctl_interlock ep_ctl_interlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_rd         (cpu_rd),
  .cpu_wr_ctl     (cpu_wr_ctl),
  .cpu_wr_cnt     (cpu_wr_cnt),
  .cpu_wdata      (cpu_wdata),
  .sie_in_acked   (sie_in_acked),
  .sie_out_done   (sie_out_done),
  .sie_mode_wr    (sie_mode_wr),
  .sie_mode       (sie_mode),
  .sie_upd        (sie_upd),
  .setup_win      (setup_win),
  .ctl_rdata      (ctl_rdata),
  .cnt_rdata      (cnt_rdata),
  .lock_o         (lock_o),
  .buf_wr_en      (buf_wr_en),
  .buf_wr_blocked (buf_wr_blocked)
);

// File: tb/tb_ep_ctl_interlock.sv
module tb_ep_ctl_interlock;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd, cpu_wr_ctl, cpu_wr_cnt, cpu_wr_buf;
  logic [7:0] cpu_wdata;
  logic sie_setup_start, sie_ack_sent, sie_in_acked, sie_out_done;
  logic sie_txn_acked, sie_mode_wr, sie_cnt_wr;
  logic [3:0] sie_mode;
  logic [CW-1:0] sie_cnt;
  logic [7:0] ctl_rdata;
  logic [CW-1:0] cnt_rdata;
  logic lock_o, buf_wr_en, buf_wr_blocked;

  always #2 clk = ~clk;

  ep_ctl_interlock #(.CNT_W(CW)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int m_su, m_in, m_out, m_ack, m_win, m_lock, m_mode, m_cnt;

  function automatic void chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  task automatic idle();
    cpu_rd = 0; cpu_wr_ctl = 0; cpu_wr_cnt = 0; cpu_wr_buf = 0; cpu_wdata = 0;
    sie_setup_start = 0; sie_ack_sent = 0; sie_in_acked = 0; sie_out_done = 0;
    sie_txn_acked = 0; sie_mode_wr = 0; sie_mode = 0; sie_cnt_wr = 0; sie_cnt = 0;
  endtask

  function automatic int exp_byte();
    return (m_su << 7) | (m_in << 6) | (m_out << 5) | (m_ack << 4) | m_mode;
  endfunction

  // model update at the edge, compare a little later
  always @(posedge clk) begin
    if (!rst_n) begin
      m_su = 0; m_in = 0; m_out = 0; m_ack = 0; m_win = 0;
      m_lock = 0; m_mode = 0; m_cnt = 0;
    end else begin
      int pass_wr, any_sie, old_win;
      pass_wr = (m_lock == 0 || cpu_rd) ? 1 : 0;
      any_sie = (sie_setup_start || sie_in_acked || sie_out_done ||
                 sie_txn_acked || sie_mode_wr || sie_cnt_wr) ? 1 : 0;
      old_win = m_win;
      if (cpu_wr_ctl && pass_wr) begin
        m_su = 0; m_in = 0; m_out = 0; m_ack = 0; m_mode = cpu_wdata & 15;
      end
      if (cpu_wr_cnt && pass_wr) m_cnt = cpu_wdata;
      if (sie_setup_start || old_win) m_su = 1;
      if (sie_in_acked)  m_in = 1;
      if (sie_out_done)  m_out = 1;
      if (sie_txn_acked) m_ack = 1;
      if (sie_mode_wr)   m_mode = sie_mode;
      if (sie_cnt_wr)    m_cnt = sie_cnt;
      if (sie_setup_start) m_win = 1;
      else if (sie_ack_sent) m_win = 0;
      if (any_sie) m_lock = 1;
      else if (cpu_rd) m_lock = 0;
    end
    #1;
    if (rst_n) begin
      chk({phase, " ctl"}, ctl_rdata, exp_byte());
      chk({phase, " cnt"}, cnt_rdata, m_cnt);
      chk({phase, " lock"}, lock_o, m_lock);
      chk({phase, " R8 buf"}, buf_wr_en,
          (cpu_wr_buf && !(m_su || m_win)) ? 1 : 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 reset byte", ctl_rdata, 0);
    chk("R1 reset lock", lock_o, 0);
    rst_n = 1;

    // R6: unlocked write, data upper nibble discarded
    phase = "R6";
    @(negedge clk); cpu_wr_ctl = 1; cpu_wdata = 8'hF5;
    @(negedge clk); idle(); cpu_wr_cnt = 1; cpu_wdata = 8'h23;
    @(negedge clk); idle();
    chk("R6 ctl after write", ctl_rdata, 8'h05);
    chk("R6 cnt after write", cnt_rdata, 8'h23);

    // R9 / R2: IN ack sets flag and lock
    phase = "R9";
    sie_in_acked = 1;
    @(negedge clk); idle();
    chk("R9 IN flag", ctl_rdata, 8'h45);
    chk("R2 lock set", lock_o, 1);
    // R4: locked writes dropped
    phase = "R4";
    cpu_wr_ctl = 1; cpu_wdata = 8'h0A;
    @(negedge clk); idle(); cpu_wr_cnt = 1; cpu_wdata = 8'h77;
    @(negedge clk); idle();
    chk("R4 ctl held", ctl_rdata, 8'h45);
    chk("R4 cnt held", cnt_rdata, 8'h23);
    // R3: read releases
    phase = "R3";
    cpu_rd = 1;
    @(negedge clk); idle();
    chk("R3 lock clear", lock_o, 0);
    // R3: SIE update and read together keep the lock
    cpu_rd = 1; sie_cnt_wr = 1; sie_cnt = 8'h40;
    @(negedge clk); idle();
    chk("R3 tie locks", lock_o, 1);

    // R5: read strobe inside write cycle passes the write
    phase = "R5";
    cpu_rd = 1; cpu_wr_ctl = 1; cpu_wdata = 8'hC7;
    @(negedge clk); idle();
    chk("R5 write through", ctl_rdata, 8'h07);
    chk("R5 unlocked", lock_o, 0);

    // R7 / R8: setup window
    phase = "R7";
    sie_setup_start = 1;
    @(negedge clk); idle();
    chk("R7 setup set", ctl_rdata[7], 1);
    cpu_wr_buf = 1;
    #0 chk("R8 buf masked", buf_wr_en, 0);
    @(negedge clk); idle();
    cpu_rd = 1; cpu_wr_ctl = 1; cpu_wdata = 8'h02;
    @(negedge clk); idle();
    chk("R7 pinned", ctl_rdata, 8'h82);
    sie_ack_sent = 1; cpu_rd = 1; cpu_wr_ctl = 1; cpu_wdata = 8'h03;
    @(negedge clk); idle();
    chk("R7 pinned on ack", ctl_rdata[7], 1);
    cpu_wr_ctl = 1; cpu_wdata = 8'h04;
    @(negedge clk); idle();
    chk("R7 cleared after", ctl_rdata, 8'h04);
    cpu_wr_buf = 1;
    #0 chk("R8 buf open", buf_wr_en, 1);
    @(negedge clk); idle();

    // R10: SIE set beats CPU clear
    phase = "R10";
    sie_out_done = 1; sie_txn_acked = 1; cpu_wr_ctl = 1; cpu_wdata = 8'h01;
    @(negedge clk); idle();
    chk("R10 set wins", ctl_rdata, 8'h31);
    chk("R10 lock", lock_o, 1);

    // R11: SIE mode beats CPU mode
    phase = "R11";
    cpu_rd = 1; sie_mode_wr = 1; sie_mode = 4'h9; cpu_wr_ctl = 1; cpu_wdata = 8'h02;
    @(negedge clk); idle();
    chk("R11 sie mode", ctl_rdata[3:0], 9);

    // random stream against the model
    phase = "R2 rand";
    for (int i = 0; i < 3000; i++) begin
      cpu_rd          = ($urandom % 4) == 0;
      cpu_wr_ctl      = ($urandom % 3) == 0;
      cpu_wr_cnt      = ($urandom % 4) == 0;
      cpu_wr_buf      = ($urandom % 2) == 0;
      cpu_wdata       = 8'($urandom);
      sie_setup_start = ($urandom % 16) == 0;
      sie_ack_sent    = ($urandom % 6) == 0;
      sie_in_acked    = ($urandom % 10) == 0;
      sie_out_done    = ($urandom % 10) == 0;
      sie_txn_acked   = ($urandom % 10) == 0;
      sie_mode_wr     = ($urandom % 12) == 0;
      sie_mode        = 4'($urandom);
      sie_cnt_wr      = ($urandom % 12) == 0;
      sie_cnt         = 8'($urandom);
      @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule